// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block decides when a processor core goes into a low-power state and when it comes back out. A small control register holds two bits: one arms sleep and the other picks the depth. When software issues its sleep instruction, the core signals this with a one-cycle strobe. If sleep is armed, the core then drops into either a light state or a deep state. In the light state only the core clock enable is removed. In the deep state the peripheral clock enable is removed as well.

In the light state, any enabled interrupt request brings the core back. The block then reports that execution resumes at the instruction after the sleep instruction. In the deep state only level-type requests and a reset request can wake the core. A level request first starts a start-up delay, counted in pulses of a free-running slow tick. When the delay expires, the core wakes only if an enabled level request is still present. If none is present, the block returns to the deep state. A reset request wakes the core from any sleep state at once and reports a restart from the reset vector. The control register keeps its value through sleep and wake.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the outputs are as follows: cpu_clk_en=1, per_clk_en=1, sleeping=0, wake_valid=0 and ctrl_q=2'b00.
- R2: A clock edge with cfg_wr=1 loads cfg_wdata into ctrl_q, visible after that edge. Bit 0 is the sleep-arm bit. Bit 1 is the depth bit: 0 selects light sleep and 1 selects deep sleep.
- R3: When sleep_op is asserted while the sleep-arm bit is 0, it has no effect: sleeping stays 0 and both clock enables stay 1.
- R4: When sleep_op is asserted while running, with the arm bit at 1 and the depth bit at 0, the next edge sets sleeping=1, cpu_clk_en=0 and per_clk_en=1.
- R5: When sleep_op is asserted while running, with the arm bit at 1 and the depth bit at 1, the next edge sets sleeping=1, cpu_clk_en=0 and per_clk_en=0.
- R6: In light sleep, a request on line i with irq_req[i]=1 and irq_en[i]=1 wakes the core at the next edge, whatever its irq_level[i] value. The wake sets both clock enables to 1 and sleeping to 0. It also raises wake_valid for exactly one cycle, with wake_to_reset=0, meaning execution resumes after the sleep instruction.
- R7: A request whose irq_en bit is 0 never wakes the core.
- R8: In deep sleep, an enabled request with irq_level=0 (edge type) does not wake the core.
- R9: In deep sleep, an enabled request with irq_level=1 starts the start-up delay. The clock enables stay 0 while the delay runs. The core wakes as in R6 only on the edge after the DELAY_TICKS-th slow_tick pulse counted in the delay, and only if an enabled level request is present at that edge. Otherwise the block goes back to deep sleep.
- R10: In any sleep state, including the start-up delay, rst_req=1 wakes the core at the next edge with wake_valid=1 and wake_to_reset=1. It takes priority over interrupt requests. While the core is running, rst_req has no effect.
- R11: Entering sleep and waking from it leave ctrl_q unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 2 | Control register write data: bit 0 arms sleep, bit 1 selects deep sleep |
| ctrl_q | output | 2 | Control register contents |
| sleep_op | input | 1 | One-cycle strobe from the sleep instruction |
| irq_req | input | N_IRQ | Interrupt request per line |
| irq_en | input | N_IRQ | Interrupt enable per line (mask and global enable combined) |
| irq_level | input | N_IRQ | 1 marks the line as level-sensed, 0 as edge-sensed |
| rst_req | input | 1 | Reset request acting as a wake source |
| slow_tick | input | 1 | One-cycle pulse from the free-running slow clock |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| sleeping | output | 1 | High while in any sleep state or in the start-up delay |
| wake_valid | output | 1 | One-cycle pulse on the first running cycle after a wake |
| wake_to_reset | output | 1 | With wake_valid: 1 means restart from the reset vector, 0 means resume after the sleep instruction |

## Verification
The bench builds the block with N_IRQ=3 and DELAY_TICKS=4. A delay of four ticks is short enough to step through one pulse at a time. This lets the bench check that no wake happens after three ticks, that the wake happens after the fourth, and that the block falls back to deep sleep when the level has dropped before expiry. Three lines give a mix of enabled, masked, edge and level requests in each random trial. This covers the single-line, multi-line and all-masked cases.

// File: rtl/sleep_pkg.sv
// Shared types for the sleep and wake-up controller.
// Assumes: none beyond a 2-bit control register layout.
package sleep_pkg;

    // Controller states; STARTUP is the deep-sleep start-up delay
    typedef enum logic [1:0] {
        S_RUN     = 2'd0,
        S_IDLE    = 2'd1,
        S_PDOWN   = 2'd2,
        S_STARTUP = 2'd3
    } sleep_state_t;

    // Control register layout: bit 1 depth, bit 0 arm
    typedef struct packed {
        logic deep;
        logic arm;
    } sleep_ctrl_t;

endpackage

// File: rtl/sleep_ctrl_reg.sv
// Control register holding the sleep-arm and depth bits.
// Assumes: writes may happen at any time; nothing else modifies it.
module sleep_ctrl_reg
    import sleep_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [1:0]  wdata,
    output sleep_ctrl_t ctrl
);

    // Load on write, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr)
            ctrl <= sleep_ctrl_t'(wdata);
    end

endmodule

// File: rtl/wake_detect.sv
// Combines per-line interrupt requests into wake qualifiers.
// Assumes: irq_en already includes the global interrupt enable.
module wake_detect #(
    parameter int N_IRQ = 2
) (
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_level,
    output logic             any_hit,
    output logic             any_level_hit
);

    logic [N_IRQ-1:0] hit;
    logic [N_IRQ-1:0] lvl_hit;

    // Per-line qualification
    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        assign hit[i]     = irq_req[i] & irq_en[i];
        assign lvl_hit[i] = irq_req[i] & irq_en[i] & irq_level[i];
    end

    assign any_hit       = |hit;
    assign any_level_hit = |lvl_hit;

endmodule

// File: rtl/startup_timer.sv
// Counts slow-clock ticks during the deep-sleep start-up delay.
// Assumes: tick is a one-cycle pulse synchronous to clk.
module startup_timer #(
    parameter int DELAY_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expired
);

    localparam int CNT_W = $clog2(DELAY_TICKS + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_TICKS);

    logic [CNT_W-1:0] cnt;

    // Clear outside the delay, count ticks until the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (run && tick && cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIMIT);

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

endmodule

// File: rtl/sleep_wake_ctrl.sv
// Sleep entry and wake-up state machine with clock-enable outputs.
// Assumes: sleep_op is a one-cycle strobe; rst_req is a reset event
// seen as a wake source, separate from this block's own rst_n.
module sleep_wake_ctrl
    import sleep_pkg::*;
#(
    parameter int N_IRQ       = 2,
    parameter int DELAY_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_wdata,
    output logic [1:0]       ctrl_q,
    input  logic             sleep_op,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_level,
    input  logic             rst_req,
    input  logic             slow_tick,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             sleeping,
    output logic             wake_valid,
    output logic             wake_to_reset
);

    sleep_ctrl_t  ctrl;
    sleep_state_t state, nxt_state;
    logic         any_hit, any_level_hit, tmr_expired;
    logic         nxt_wake, nxt_to_reset;

    sleep_ctrl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .ctrl  (ctrl)
    );

    wake_detect #(.N_IRQ(N_IRQ)) u_detect (
        .irq_req       (irq_req),
        .irq_en        (irq_en),
        .irq_level     (irq_level),
        .any_hit       (any_hit),
        .any_level_hit (any_level_hit)
    );

    startup_timer #(.DELAY_TICKS(DELAY_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state != S_STARTUP),
        .run     (state == S_STARTUP),
        .tick    (slow_tick),
        .expired (tmr_expired)
    );

    // Next-state and wake-cause decision
    always_comb begin
        nxt_state    = state;
        nxt_wake     = 1'b0;
        nxt_to_reset = 1'b0;
        unique case (state)
            S_RUN: begin
                if (sleep_op && ctrl.arm)
                    nxt_state = ctrl.deep ? S_PDOWN : S_IDLE;
            end
            S_IDLE: begin
                if (rst_req || any_hit) begin
                    nxt_state    = S_RUN;
                    nxt_wake     = 1'b1;
                    nxt_to_reset = rst_req;
                end
            end
            S_PDOWN: begin
                if (rst_req) begin
                    nxt_state    = S_RUN;
                    nxt_wake     = 1'b1;
                    nxt_to_reset = 1'b1;
                end else if (any_level_hit) begin
                    nxt_state = S_STARTUP;
                end
            end
            S_STARTUP: begin
                if (rst_req) begin
                    nxt_state    = S_RUN;
                    nxt_wake     = 1'b1;
                    nxt_to_reset = 1'b1;
                end else if (tmr_expired) begin
                    nxt_state = any_level_hit ? S_RUN : S_PDOWN;
                    nxt_wake  = any_level_hit;
                end
            end
            default: nxt_state = S_RUN;
        endcase
    end

    // State and wake-report registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= S_RUN;
            wake_valid    <= 1'b0;
            wake_to_reset <= 1'b0;
        end else begin
            state         <= nxt_state;
            wake_valid    <= nxt_wake;
            wake_to_reset <= nxt_to_reset;
        end
    end

    assign ctrl_q     = ctrl;
    assign sleeping   = (state != S_RUN);
    assign cpu_clk_en = (state == S_RUN);
    assign per_clk_en = (state == S_RUN) || (state == S_IDLE);

    assert_entry_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && sleep_op && !ctrl.arm) |=> !sleeping);

    assert_idle_clocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (!cpu_clk_en && per_clk_en));

    assert_deep_clocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PDOWN || state == S_STARTUP) |-> (!cpu_clk_en && !per_clk_en));

    assert_wake_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> !wake_valid);

    assert_deep_edge_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PDOWN && !rst_req) |=> sleeping);

    assert_no_early_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STARTUP && !tmr_expired && !rst_req) |=> sleeping);

    assert_reset_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping && rst_req) |=> (wake_valid && wake_to_reset));

    assert_ctrl_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(ctrl_q));

endmodule

// File: tb/test_sleep_wake_ctrl.sv
`timescale 1ns/1ps
module test_sleep_wake_ctrl;

    localparam int NI = 3;
    localparam int DT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_wdata = 2'b00;
    logic [1:0]    ctrl_q;
    logic          sleep_op = 1'b0;
    logic [NI-1:0] irq_req = '0, irq_en = '0, irq_level = '0;
    logic          rst_req = 1'b0;
    logic          slow_tick = 1'b0;
    logic          cpu_clk_en, per_clk_en, sleeping, wake_valid, wake_to_reset;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sleep_wake_ctrl #(.N_IRQ(NI), .DELAY_TICKS(DT)) i_sleep_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .ctrl_q(ctrl_q), .sleep_op(sleep_op), .irq_req(irq_req),
        .irq_en(irq_en), .irq_level(irq_level), .rst_req(rst_req),
        .slow_tick(slow_tick), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .sleeping(sleeping),
        .wake_valid(wake_valid), .wake_to_reset(wake_to_reset)
    );

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected wake from light sleep per R6/R7
    function automatic bit exp_light_wake(input logic [NI-1:0] r, input logic [NI-1:0] e);
        return |(r & e);
    endfunction

    // Packs clock enables and sleeping as {cpu, per, sleeping}
    function automatic int clk_state();
        return {29'd0, cpu_clk_en, per_clk_en, sleeping};
    endfunction

    task automatic write_cfg(input logic [1:0] v);
        cfg_wr = 1'b1; cfg_wdata = v; step(); cfg_wr = 1'b0;
    endtask

    task automatic do_sleep();
        sleep_op = 1'b1; step(); sleep_op = 1'b0;
    endtask

    task automatic tick_pulse();
        slow_tick = 1'b1; step(); slow_tick = 1'b0;
    endtask

    task automatic clear_irq();
        irq_req = '0; irq_en = '0; irq_level = '0;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 clocks/sleep", clk_state(), 3'b110);
        check("R1 wake_valid", wake_valid, 0);
        check("R1 ctrl_q", ctrl_q, 0);

        // R2 register write
        write_cfg(2'b10);
        check("R2 ctrl_q load", ctrl_q, 2);

        // R3 strobe ignored when not armed
        do_sleep();
        check("R3 not armed", clk_state(), 3'b110);
        step();
        check("R3 not armed later", clk_state(), 3'b110);

        // R4 light sleep entry
        write_cfg(2'b01);
        do_sleep();
        check("R4 light sleep", clk_state(), 3'b011);

        // R7 masked request ignored
        irq_req = 3'b111; irq_en = 3'b000;
        step(); step();
        check("R7 masked", clk_state(), 3'b011);

        // R6 edge-type enabled request wakes from light sleep
        irq_req = 3'b010; irq_en = 3'b010; irq_level = 3'b000;
        step();
        clear_irq();
        check("R6 wake", clk_state(), 3'b110);
        check("R6 wake_valid", wake_valid, 1);
        check("R6 resume", wake_to_reset, 0);
        step();
        check("R6 single pulse", wake_valid, 0);
        check("R11 ctrl after light", ctrl_q, 1);

        // R10 reset request from light sleep
        do_sleep();
        irq_req = 3'b001; irq_en = 3'b001;
        rst_req = 1'b1;
        step();
        rst_req = 1'b0; clear_irq();
        check("R10 light reset wake", wake_valid, 1);
        check("R10 reset cause priority", wake_to_reset, 1);
        rst_req = 1'b1; step(); rst_req = 1'b0;
        check("R10 running ignore", wake_valid, 0);
        check("R10 running state", clk_state(), 3'b110);

        // R5 deep sleep entry
        write_cfg(2'b11);
        do_sleep();
        check("R5 deep sleep", clk_state(), 3'b001);

        // R8 edge request ignored in deep sleep
        irq_req = 3'b100; irq_en = 3'b100; irq_level = 3'b000;
        for (int k = 0; k < 3 * DT; k++) tick_pulse();
        check("R8 edge ignored", clk_state(), 3'b001);
        check("R8 no wake pulse", wake_valid, 0);

        // R9 held level wakes only after DT ticks
        irq_level = 3'b100;
        step();
        for (int k = 0; k < DT - 1; k++) tick_pulse();
        step();
        check("R9 no early wake", clk_state(), 3'b001);
        tick_pulse();
        step();
        check("R9 wake after delay", clk_state(), 3'b110);
        check("R9 wake_valid", wake_valid, 1);
        check("R9 resume cause", wake_to_reset, 0);
        clear_irq();
        check("R11 ctrl after deep", ctrl_q, 3);

        // R9 level dropped before expiry returns to deep sleep
        do_sleep();
        irq_req = 3'b001; irq_en = 3'b001; irq_level = 3'b001;
        step();
        clear_irq();
        for (int k = 0; k < DT; k++) tick_pulse();
        step(); step();
        check("R9 fall back", clk_state(), 3'b001);
        check("R9 fall back no pulse", wake_valid, 0);
        for (int k = 0; k < DT + 2; k++) tick_pulse();
        check("R9 stays deep", clk_state(), 3'b001);

        // R10 reset request from deep sleep
        rst_req = 1'b1; step(); rst_req = 1'b0;
        check("R10 deep reset wake", wake_valid, 1);
        check("R10 deep reset cause", wake_to_reset, 1);

        // R10 reset request during start-up delay
        do_sleep();
        irq_req = 3'b010; irq_en = 3'b010; irq_level = 3'b010;
        step();
        tick_pulse();
        rst_req = 1'b1; step(); rst_req = 1'b0;
        clear_irq();
        check("R10 startup reset wake", wake_valid, 1);
        check("R10 startup reset cause", wake_to_reset, 1);

        // Random trials over arm/depth and request patterns
        for (int t = 0; t < 60; t++) begin
            logic [1:0]    cfg;
            logic [NI-1:0] r, e, l;
            bit            asleep_exp;
            cfg = 2'($urandom());
            r   = NI'($urandom());
            e   = NI'($urandom());
            l   = NI'($urandom());
            write_cfg(cfg);
            do_sleep();
            asleep_exp = cfg[0];
            check("R3 R4 R5 random entry", sleeping, int'(asleep_exp));
            if (asleep_exp) begin
                check("R4 R5 random per_clk_en", per_clk_en, int'(!cfg[1]));
                irq_req = r; irq_en = e; irq_level = l;
                step();
                clear_irq();
                if (!cfg[1]) begin
                    check("R6 R7 random light wake", wake_valid,
                          int'(exp_light_wake(r, e)));
                end else begin
                    check("R8 R9 random deep no instant wake", wake_valid, 0);
                end
                if (sleeping) begin
                    rst_req = 1'b1; step(); rst_req = 1'b0;
                    check("R10 random reset wake", wake_to_reset, 1);
                end
            end
            check("R11 random ctrl held", ctrl_q, int'(cfg));
            step();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule